// File: doc/BRIEF.md
# Reset Source Capture Controller

This block collects every cause of a system reset in a small 8-bit microcontroller. It raises the internal system reset and drives the active-low reset pin low for its internal causes. It also keeps a record of which causes have fired since software last looked. The causes are power-on, the external pin, a watchdog timeout, a low-voltage pulse, a mode-reset request, an undefined opcode (with a disabled STOP counted as one) and an opcode fetch from an unmapped address.

The record is an 8-bit read-only register. Reading it clears it. Between reads it only gains bits, so several resets from different causes leave several flags set. After an internal reset the block lets the pin go and checks it once more a fixed number of cycles later. If something outside still holds the pin low at that point, the external-pin flag is added and the block stays in reset until the pin rises.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_pulse` is high, and right after it falls, the status is 0x80, `sys_rst` is 1 and `rst_pin_drive_low` is 1. The power-on pulse acts asynchronously.
- R2: Status bit positions: 7 power-on, 6 external pin, 5 watchdog, 4 illegal opcode, 3 illegal address, 2 mode reset, 1 low voltage. Bit 0 always reads 0.
- R3: A one-cycle `cause_rd` pulse clears every flag at the next clock edge. The value seen during the read cycle is the value held before the read.
- R4: A later reset never clears a flag. Resets from different causes with no read between them leave the OR of their bits.
- R5: If a read and a new cause fall in the same cycle, the new cause's bit is set after the read-clear and every other bit is 0.
- R6: An `ifetch` with `op_undefined`=1 sets bit 4 and starts an internal reset.
- R7: An `ifetch` with `op_stop`=1 sets bit 4 and resets when `stop_en`=0. It does neither when `stop_en`=1.
- R8: An `ifetch` with `addr_hit`=0 sets bit 3 and resets. A cycle with `ifetch`=0 never sets bit 3 or bit 4 and starts no reset.
- R9: An internal cause drives `rst_pin_drive_low` for DRIVE_CYCLES (64) cycles and holds `sys_rst` for DRIVE_CYCLES+SAMPLE_DELAY (96) cycles, counted from the edge that captured the cause.
- R10: If the pin is still low at the sample point SAMPLE_DELAY (32) cycles after release, bit 6 is set and `sys_rst` stays high until the pin is high again.
- R11: An external low on the pin while idle sets bit 6 and holds `sys_rst` while the pin stays low, without driving the pin.
- R12: Watchdog, low-voltage and mode-reset pulses set bits 5, 1 and 2, each with an internal reset.
- R13: CPU decode qualifiers (`ifetch` and its flags) are ignored while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| rst_pin_in | input | 1 | Level read back from the reset pin (low = reset) |
| wdog_expired | input | 1 | Watchdog timeout pulse |
| lv_pulse | input | 1 | Low-voltage detect pulse |
| mode_rst_req | input | 1 | Mode-reset request pulse |
| ifetch | input | 1 | Opcode fetch strobe |
| op_undefined | input | 1 | Fetched opcode is not in the instruction set |
| op_stop | input | 1 | Fetched opcode is STOP |
| addr_hit | input | 1 | Current address is mapped |
| stop_en | input | 1 | STOP instruction allowed |
| cause_rd | input | 1 | Status register read strobe |
| rst_pin_drive_low | output | 1 | Open-drain enable pulling the reset pin low |
| sys_rst | output | 1 | Internal system reset |
| cause_status | output | 8 | Reset cause flags |

## Verification
The bench sweeps every combination of fetch strobe, undefined-opcode flag, STOP flag, STOP enable and address-mapped flag. It works out the expected bits and reset length from arithmetic.

Two kinds of design fault are aimed at. One fires an address reset on a data access, which would reset the part on harmless data traffic. The other ignores STOP enable, which would reset the part on every STOP or on none.

It also goes after:
- a read colliding with a new cause; a design that cleared last would lose that cause;
- flag accumulation across resets; a design that overwrote the register would report only the newest cause;
- a pin held low past the sample point, which a design sampling at the wrong time or never would miss;
- decode strobes arriving during reset, which a design without gating would log as spurious illegal-opcode faults.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int unsigned FLAG_W    = 8;
  localparam int unsigned BIT_POR   = 7;
  localparam int unsigned BIT_PIN   = 6;
  localparam int unsigned BIT_WDOG  = 5;
  localparam int unsigned BIT_ILOP  = 4;
  localparam int unsigned BIT_ILAD  = 3;
  localparam int unsigned BIT_MODE  = 2;
  localparam int unsigned BIT_LV    = 1;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DRIVE = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_EXT   = 2'd3
  } seq_state_t;

  // Undefined opcode, or STOP while STOP is disabled
  function automatic logic ilop_hit(input logic undef_op, input logic stop_op,
                                    input logic stop_allowed);
    return undef_op | (stop_op & ~stop_allowed);
  endfunction

  // Total cycles the system reset is held for one internal cause
  function automatic int unsigned window_len(input int unsigned drive,
                                             input int unsigned smp);
    return drive + smp;
  endfunction

  // Power-up value of the status register
  function automatic logic [FLAG_W-1:0] por_value();
    logic [FLAG_W-1:0] v;
    v = '0;
    v[BIT_POR] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/rst_evt_decode.sv
module rst_evt_decode
  import rst_cause_pkg::*;
(
  input  logic clk,
  input  logic por_i,
  input  logic ifetch_i,
  input  logic op_undefined_i,
  input  logic op_stop_i,
  input  logic addr_hit_i,
  input  logic stop_en_i,
  input  logic cpu_in_rst_i,
  output logic ilop_evt_o,
  output logic ilad_evt_o
);

  logic fetch_live;

  assign fetch_live = ifetch_i & ~cpu_in_rst_i;
  assign ilop_evt_o = fetch_live & ilop_hit(op_undefined_i, op_stop_i, stop_en_i);
  assign ilad_evt_o = fetch_live & ~addr_hit_i;

  AST_DATA_NO_RESET: assert property (@(posedge clk) disable iff (por_i)
    !ifetch_i |-> (!ilop_evt_o && !ilad_evt_o)); // R8

  AST_GATED_IN_RST: assert property (@(posedge clk) disable iff (por_i)
    cpu_in_rst_i |-> (!ilop_evt_o && !ilad_evt_o)); // R13

endmodule

// File: rtl/rst_pin_seq.sv
module rst_pin_seq
  import rst_cause_pkg::*;
#(
  parameter int unsigned DRIVE_CYCLES = 64,
  parameter int unsigned SAMPLE_DELAY = 32,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_i,
  input  logic trig_i,
  output logic drive_low_o,
  output logic in_reset_o,
  output logic pin_evt_o
);

  localparam int unsigned MAXC = (DRIVE_CYCLES > SAMPLE_DELAY) ? DRIVE_CYCLES : SAMPLE_DELAY;
  localparam int unsigned CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] DRV_LAST = CW'(DRIVE_CYCLES - 1);
  localparam logic [CW-1:0] SMP_LAST = CW'(SAMPLE_DELAY - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_lo_s;
  seq_state_t             state_q;
  logic [CW-1:0]          cnt_q;
  logic                   sample_pt;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or posedge por_i) begin
        if (por_i) sync_q[0] <= 1'b0;
        else       sync_q[0] <= ~pin_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or posedge por_i) begin
        if (por_i) sync_q[g] <= 1'b0;
        else       sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign pin_lo_s  = sync_q[SYNC_STAGES-1];
  assign sample_pt = (state_q == SQ_WAIT) && (cnt_q == SMP_LAST);

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      state_q <= SQ_DRIVE;
      cnt_q   <= '0;
    end else if (trig_i) begin
      state_q <= SQ_DRIVE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (pin_lo_s) state_q <= SQ_EXT;
        SQ_DRIVE: begin
          if (cnt_q == DRV_LAST) begin
            state_q <= SQ_WAIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_WAIT: begin
          if (sample_pt) begin
            state_q <= pin_lo_s ? SQ_EXT : SQ_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_EXT: if (!pin_lo_s) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign drive_low_o = (state_q == SQ_DRIVE);
  assign in_reset_o  = (state_q != SQ_IDLE);
  assign pin_evt_o   = pin_lo_s && ((state_q == SQ_IDLE) || sample_pt);

  AST_DRIVE_HOLDS_RST: assert property (@(posedge clk) disable iff (por_i)
    drive_low_o |-> in_reset_o); // R9

  AST_TRIG_STARTS_DRIVE: assert property (@(posedge clk) disable iff (por_i)
    trig_i |=> drive_low_o); // R9

  AST_SAMPLE_LOW_HOLDS: assert property (@(posedge clk) disable iff (por_i)
    (sample_pt && pin_lo_s && !trig_i) |=> in_reset_o); // R10

endmodule

// File: rtl/rst_flag_reg.sv
module rst_flag_reg
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              por_i,
  input  logic              rd_i,
  input  logic [FLAG_W-1:0] set_i,
  output logic [FLAG_W-1:0] q_o
);

  logic [FLAG_W-1:0] set_m;
  logic [FLAG_W-1:0] kept;

  always_comb begin
    set_m          = set_i;
    set_m[BIT_POR] = 1'b0;
    set_m[0]       = 1'b0;
  end

  assign kept = rd_i ? '0 : q_o;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) q_o <= por_value();
    else       q_o <= kept | set_m;
  end

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (por_i)
    (rd_i && set_i == '0) |=> (q_o == '0)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por_i)
    !rd_i |=> ((q_o & $past(q_o)) == $past(q_o))); // R4

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (por_i)
    (set_i[BIT_PIN:1] != '0) |=> ((q_o[BIT_PIN:1] & $past(set_i[BIT_PIN:1])) == $past(set_i[BIT_PIN:1]))); // R5

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int unsigned DRIVE_CYCLES = 64,
  parameter int unsigned SAMPLE_DELAY = 32,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       rst_pin_in,
  input  logic       wdog_expired,
  input  logic       lv_pulse,
  input  logic       mode_rst_req,
  input  logic       ifetch,
  input  logic       op_undefined,
  input  logic       op_stop,
  input  logic       addr_hit,
  input  logic       stop_en,
  input  logic       cause_rd,
  output logic       rst_pin_drive_low,
  output logic       sys_rst,
  output logic [7:0] cause_status
);

  logic              ilop_evt;
  logic              ilad_evt;
  logic              pin_evt;
  logic              int_trig;
  logic [FLAG_W-1:0] set_vec;

  rst_evt_decode u_dec (
    .clk            (clk),
    .por_i          (por_pulse),
    .ifetch_i       (ifetch),
    .op_undefined_i (op_undefined),
    .op_stop_i      (op_stop),
    .addr_hit_i     (addr_hit),
    .stop_en_i      (stop_en),
    .cpu_in_rst_i   (sys_rst),
    .ilop_evt_o     (ilop_evt),
    .ilad_evt_o     (ilad_evt)
  );

  assign int_trig = wdog_expired | lv_pulse | mode_rst_req | ilop_evt | ilad_evt;

  rst_pin_seq #(
    .DRIVE_CYCLES (DRIVE_CYCLES),
    .SAMPLE_DELAY (SAMPLE_DELAY),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_seq (
    .clk         (clk),
    .por_i       (por_pulse),
    .pin_i       (rst_pin_in),
    .trig_i      (int_trig),
    .drive_low_o (rst_pin_drive_low),
    .in_reset_o  (sys_rst),
    .pin_evt_o   (pin_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_PIN]  = pin_evt;
    set_vec[BIT_WDOG] = wdog_expired;
    set_vec[BIT_ILOP] = ilop_evt;
    set_vec[BIT_ILAD] = ilad_evt;
    set_vec[BIT_MODE] = mode_rst_req;
    set_vec[BIT_LV]   = lv_pulse;
  end

  rst_flag_reg u_flags (
    .clk   (clk),
    .por_i (por_pulse),
    .rd_i  (cause_rd),
    .set_i (set_vec),
    .q_o   (cause_status)
  );

  AST_BIT0_LOW: assert property (@(posedge clk) disable iff (por_pulse)
    cause_status[0] == 1'b0); // R2

  AST_CAUSE_RESETS: assert property (@(posedge clk) disable iff (por_pulse)
    (wdog_expired || lv_pulse || mode_rst_req) |=> sys_rst); // R12

endmodule

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;

  localparam int DRV = 64;
  localparam int SMP = 32;
  localparam int WIN = DRV + SMP;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_pulse, wdog_expired, lv_pulse, mode_rst_req;
  logic ifetch, op_undefined, op_stop, addr_hit, stop_en, cause_rd;
  logic ext_low;
  logic rst_pin_in, rst_pin_drive_low, sys_rst;
  logic [7:0] cause_status;

  assign rst_pin_in = ~(rst_pin_drive_low | ext_low);

  rst_cause_ctrl uut (
    .clk(clk), .por_pulse(por_pulse), .rst_pin_in(rst_pin_in),
    .wdog_expired(wdog_expired), .lv_pulse(lv_pulse), .mode_rst_req(mode_rst_req),
    .ifetch(ifetch), .op_undefined(op_undefined), .op_stop(op_stop),
    .addr_hit(addr_hit), .stop_en(stop_en), .cause_rd(cause_rd),
    .rst_pin_drive_low(rst_pin_drive_low), .sys_rst(sys_rst),
    .cause_status(cause_status)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic count_rst(output int len);
    len = 0;
    while (sys_rst && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic count_drv(output int len);
    len = 0;
    while (rst_pin_drive_low && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic rd_clear(output logic [7:0] seen);
    seen = cause_status;
    cause_rd = 1'b1;
    @(negedge clk);
    cause_rd = 1'b0;
  endtask

  task automatic pulse_src(input int which);
    case (which)
      0: wdog_expired = 1'b1;
      1: lv_pulse = 1'b1;
      default: mode_rst_req = 1'b1;
    endcase
    @(negedge clk);
    wdog_expired = 1'b0;
    lv_pulse = 1'b0;
    mode_rst_req = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len;
    int len2;
    logic [7:0] seen;
    logic [7:0] acc;

    por_pulse = 1'b1;
    wdog_expired = 0; lv_pulse = 0; mode_rst_req = 0;
    ifetch = 0; op_undefined = 0; op_stop = 0; addr_hit = 1; stop_en = 1;
    cause_rd = 0; ext_low = 0;
    repeat (3) @(negedge clk);
    chk("R1 status during por", cause_status, 8'h80);
    chk("R1 sys_rst during por", sys_rst, 1);
    chk("R1 pin drive during por", rst_pin_drive_low, 1);
    por_pulse = 1'b0;
    count_drv(len);
    chk("R9 drive length after por", len, DRV);
    count_rst(len);
    chk("R9 sample wait after por", len, SMP);
    chk("R1 status after por window", cause_status, 8'h80);

    rd_clear(seen);
    chk("R3 value seen on read", seen, 8'h80);
    chk("R3 cleared after read", cause_status, 8'h00);

    // R12: single-cause resets: wdog->bit5, lv->bit1, mode->bit2
    for (int s = 0; s < 3; s++) begin
      pulse_src(s);
      acc = (s == 0) ? 8'h20 : (s == 1) ? 8'h02 : 8'h04;
      chk("R12 cause bit", cause_status, acc);
      chk("R9 pin driven at start", rst_pin_drive_low, 1);
      count_rst(len);
      chk("R9 reset window", len, WIN);
      rd_clear(seen);
    end

    // R4: accumulate across resets
    for (int s = 0; s < 3; s++) begin
      pulse_src(s);
      count_rst(len);
    end
    chk("R4 flags accumulate", cause_status, 8'h26);
    chk("R2 bit0 reads zero", cause_status[0], 0);

    // R5: read and new cause in same cycle
    cause_rd = 1'b1;
    lv_pulse = 1'b1;
    @(negedge clk);
    cause_rd = 1'b0;
    lv_pulse = 1'b0;
    chk("R5 new cause survives read", cause_status, 8'h02);
    count_rst(len);
    rd_clear(seen);

    // R6 R7 R8: sweep decode qualifiers
    for (int c = 0; c < 32; c++) begin
      logic f, u, sp, en, m, il, ad;
      int expv;
      f = c[4]; u = c[3]; sp = c[2]; en = c[1]; m = c[0];
      il = f & (u | (sp & ~en));
      ad = f & ~m;
      expv = (int'(il) << 4) | (int'(ad) << 3);
      ifetch = f; op_undefined = u; op_stop = sp; stop_en = en; addr_hit = m;
      @(negedge clk);
      ifetch = 0; op_undefined = 0; op_stop = 0; stop_en = 1; addr_hit = 1;
      chk(il ? "R6 R7 illegal opcode flags" : "R7 R8 decode flags", cause_status, expv);
      count_rst(len);
      chk(f ? "R6 R7 R8 reset length" : "R8 data access no reset", len, (expv != 0) ? WIN : 0);
      rd_clear(seen);
    end

    // R13: decode ignored during reset
    pulse_src(0);
    repeat (5) @(negedge clk);
    rd_clear(seen);
    ifetch = 1; op_undefined = 1; addr_hit = 0;
    @(negedge clk);
    ifetch = 0; op_undefined = 0; addr_hit = 1;
    count_rst(len);
    chk("R13 decode ignored in reset", cause_status, 8'h00);
    chk("R13 window not extended", len, WIN - 7);

    // R10: pin held low past the sample point
    pulse_src(0);
    ext_low = 1'b1;
    repeat (WIN + 5) @(negedge clk);
    chk("R10 held in reset", sys_rst, 1);
    chk("R10 pin flag added", cause_status, 8'h60);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 leaves reset on release", sys_rst, 0);
    rd_clear(seen);

    // R11: external reset from idle
    ext_low = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 sys_rst on external low", sys_rst, 1);
    chk("R11 pin not driven", rst_pin_drive_low, 0);
    chk("R11 pin flag", cause_status, 8'h40);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 release", sys_rst, 0);
    count_rst(len2);
    chk("R11 idle after release", len2, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule